// File: doc/BRIEF.md
# Transactional Commit/Rollback FIFO

A single-clock FIFO in which every accepted write first lands in a tentative region of the storage. The reader cannot see these words until the writer issues a commit. A rollback instead throws away every tentative word and hands its storage back to the writer. A producer can therefore stream a packet or record into the queue and decide only at the end whether the consumer ever sees it. One example is dropping a frame whose trailing check failed, without a separate staging buffer.

The read side works as first-word-fall-through. The oldest committed word sits on the data output while valid is high, and asserting got consumes it. Each side also has an optional coarse level indicator: committed words available on the read side, and guaranteed free slots on the write side. Both are quantised to a parameterised number of bits. Because tentative words hold storage, the queue can report full while nothing is yet readable.

Top module: `txn_fifo`

## Requirements
- R1: The capacity is MIN_DEPTH rounded up to the next power of two, which is 16 with the default MIN_DEPTH of 10. full_o rises once 16 words are held, whether committed or tentative.
- R2: Words written since the last commit or rollback are invisible to the reader. valid_o stays low, and the read-side level does not count them, until a commit.
- R3: A put while full_o is high is ignored. Tentative words alone can make full_o high while valid_o is low.
- R4: A commit makes every word written since the previous commit or rollback readable, including a word put in the same cycle.
- R5: A rollback discards every word written since the previous commit or rollback, including a word put in the same cycle, and frees their slots for writing. Commit and rollback are never asserted together.
- R6: While valid_o is high, data_o shows the oldest committed word. got_i removes that word in the same clock edge.
- R7: got_i while valid_o is low has no effect on the queue.
- R8: Asynchronous active-low reset empties the queue: valid_o=0, full_o=0, fill_lvl_o=0 and free_lvl_o at its maximum.
- R9: fill_lvl_o equals floor(committed_words * 2^FILL_LVL_W / 16), saturated at 2^FILL_LVL_W-1. It is combinational from the current state.
- R10: free_lvl_o equals floor(free_slots * 2^FREE_LVL_W / 16), saturated at 2^FREE_LVL_W-1. Here free_slots is 16 minus all held words, both committed and tentative.
- R11: Words leave in the order they were accepted, across any number of commit groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| put_i | input | 1 | Write request |
| data_i | input | DATA_W | Write data |
| full_o | output | 1 | No slot free for writing |
| free_lvl_o | output | max(1,FREE_LVL_W) | Quantised guaranteed free space |
| commit_i | input | 1 | Publish all tentative words |
| rollback_i | input | 1 | Discard all tentative words |
| got_i | input | 1 | Consume the head word |
| data_o | output | DATA_W | Head word |
| valid_o | output | 1 | Head word is committed and readable |
| fill_lvl_o | output | max(1,FILL_LVL_W) | Quantised committed fill |

## Verification
A commit marker left behind or run ahead of the write pointer shows up at once. In the first cycle after the wrong commit or rollback, valid_o or the read-side level disagrees with the model. A write pointer that fails to rewind appears as a free-level or full mismatch in the next cycle, and again as stale data once the reader reaches those slots. A corrupted read pointer appears as a wrong data_o word on the next valid cycle. Because the model is compared on every clock, any of these faults is reported within one to a few cycles of the stimulus that caused it.

// File: rtl/txn_fifo_pkg.sv
package txn_fifo_pkg;
  function automatic int unsigned port_w(int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction
endpackage

// File: rtl/txn_fifo_ptrs.sv
module txn_fifo_ptrs #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            put_i,
  input  logic            commit_i,
  input  logic            rollback_i,
  input  logic            got_i,
  output logic [ADDR_W:0] wr_ptr_o,
  output logic [ADDR_W:0] rd_ptr_o,
  output logic [ADDR_W:0] cm_ptr_o,
  output logic            wr_en_o,
  output logic            full_o,
  output logic            valid_o
);
  logic [ADDR_W:0] wr_q, rd_q, cm_q, wr_nxt;
  logic            rd_en;

  // wrap bit differs, address equal -> full
  assign full_o  = (wr_q[ADDR_W] != rd_q[ADDR_W]) &&
                   (wr_q[ADDR_W-1:0] == rd_q[ADDR_W-1:0]);
  assign valid_o = (cm_q != rd_q);
  assign wr_en_o = put_i && !full_o;
  assign rd_en   = got_i && valid_o;
  assign wr_nxt  = wr_q + {{ADDR_W{1'b0}}, wr_en_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
      cm_q <= '0;
    end else begin
      rd_q <= rd_q + {{ADDR_W{1'b0}}, rd_en};
      if (rollback_i) wr_q <= cm_q;
      else            wr_q <= wr_nxt;
      if (commit_i)   cm_q <= wr_nxt;
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign cm_ptr_o = cm_q;
endmodule

// File: rtl/txn_fifo_mem.sv
module txn_fifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) store_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/txn_fifo_level.sv
module txn_fifo_level #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LVL_W  = 2,
  localparam int unsigned OUT_W = txn_fifo_pkg::port_w(LVL_W)
) (
  input  logic [ADDR_W:0]  amount_i,
  output logic [OUT_W-1:0] lvl_o
);
  generate
    if (LVL_W == 0) begin : g_off
      logic unused_amount;
      assign unused_amount = ^amount_i;
      assign lvl_o = '0;
    end else begin : g_on
      localparam int unsigned SH   = (ADDR_W >= LVL_W) ? ADDR_W - LVL_W : 0;
      localparam int unsigned KMAX = (1 << LVL_W) - 1;
      // threshold compare: largest k with amount >= k * DEPTH / 2^LVL_W
      always_comb begin
        lvl_o = '0;
        for (int unsigned k = 1; k <= KMAX; k++) begin
          if (amount_i >= (ADDR_W+1)'(k << SH)) lvl_o = OUT_W'(k);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/txn_fifo.sv
module txn_fifo #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned MIN_DEPTH  = 10,
  parameter int unsigned FREE_LVL_W = 2,
  parameter int unsigned FILL_LVL_W = 2,
  localparam int unsigned FREE_OW   = txn_fifo_pkg::port_w(FREE_LVL_W),
  localparam int unsigned FILL_OW   = txn_fifo_pkg::port_w(FILL_LVL_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               put_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               full_o,
  output logic [FREE_OW-1:0] free_lvl_o,
  input  logic               commit_i,
  input  logic               rollback_i,
  input  logic               got_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               valid_o,
  output logic [FILL_OW-1:0] fill_lvl_o
);
  localparam int unsigned ADDR_W = (MIN_DEPTH < 2) ? 1 : $clog2(MIN_DEPTH);
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [ADDR_W:0] wr_ptr, rd_ptr, cm_ptr;
  logic [ADDR_W:0] used_cnt, free_cnt, ready_cnt;
  logic            wr_en;

  txn_fifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .put_i      (put_i),
    .commit_i   (commit_i),
    .rollback_i (rollback_i),
    .got_i      (got_i),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .cm_ptr_o   (cm_ptr),
    .wr_en_o    (wr_en),
    .full_o     (full_o),
    .valid_o    (valid_o)
  );

  txn_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_ptr[ADDR_W-1:0]),
    .wdata_i (data_i),
    .raddr_i (rd_ptr[ADDR_W-1:0]),
    .rdata_o (data_o)
  );

  assign used_cnt  = wr_ptr - rd_ptr;
  assign free_cnt  = (ADDR_W+1)'(DEPTH) - used_cnt;
  assign ready_cnt = cm_ptr - rd_ptr;

  txn_fifo_level #(.ADDR_W(ADDR_W), .LVL_W(FREE_LVL_W)) u_free_lvl (
    .amount_i (free_cnt),
    .lvl_o    (free_lvl_o)
  );

  txn_fifo_level #(.ADDR_W(ADDR_W), .LVL_W(FILL_LVL_W)) u_fill_lvl (
    .amount_i (ready_cnt),
    .lvl_o    (fill_lvl_o)
  );
endmodule

// File: rtl/txn_fifo_chk.sv
module txn_fifo_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            put_i,
  input logic            commit_i,
  input logic            rollback_i,
  input logic            got_i,
  input logic            full_i,
  input logic            valid_i,
  input logic [ADDR_W:0] wr_ptr_i,
  input logic [ADDR_W:0] rd_ptr_i,
  input logic [ADDR_W:0] cm_ptr_i
);
  localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1 << ADDR_W);

  logic [ADDR_W:0] held, ready;
  assign held  = wr_ptr_i - rd_ptr_i;
  assign ready = cm_ptr_i - rd_ptr_i;

  p_marker_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready <= held) && (held <= DEPTH));

  p_marker_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !rollback_i) |=> $stable(cm_ptr_i));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (put_i && full_i && !rollback_i) |=> $stable(wr_ptr_i));

  p_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !rollback_i) |=> (cm_ptr_i == wr_ptr_i));

  p_rollback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollback_i && !commit_i) |=> (wr_ptr_i == cm_ptr_i));

  p_empty_got_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (got_i && !valid_i) |=> $stable(rd_ptr_i));
endmodule

bind txn_fifo txn_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .put_i      (put_i),
  .commit_i   (commit_i),
  .rollback_i (rollback_i),
  .got_i      (got_i),
  .full_i     (full_o),
  .valid_i    (valid_o),
  .wr_ptr_i   (wr_ptr),
  .rd_ptr_i   (rd_ptr),
  .cm_ptr_i   (cm_ptr)
);

// File: tb/tb_txn_fifo.sv
`timescale 1ns/1ps
module tb_txn_fifo;
  localparam int CAP = 16;
  localparam int LW  = 2;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       put_i = 0, commit_i = 0, rollback_i = 0, got_i = 0;
  logic [7:0] data_i = '0;
  logic       full_o, valid_o;
  logic [7:0] data_o;
  logic [1:0] free_lvl_o, fill_lvl_o;

  int checks = 0, failures = 0;
  logic [7:0] cq[$];   // committed words
  logic [7:0] pq[$];   // tentative words

  always #2.5 clk = ~clk;

  txn_fifo dut (
    .clk_i(clk), .rst_ni(rst_ni), .put_i(put_i), .data_i(data_i),
    .full_o(full_o), .free_lvl_o(free_lvl_o), .commit_i(commit_i),
    .rollback_i(rollback_i), .got_i(got_i), .data_o(data_o),
    .valid_o(valid_o), .fill_lvl_o(fill_lvl_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int quant(input int n);
    int q = n * (1 << LW) / CAP;
    return (q > (1 << LW) - 1) ? (1 << LW) - 1 : q;
  endfunction

  task automatic compare();
    int held = cq.size() + pq.size();
    chk(full_o == (held == CAP), "R1/R3 full_o", full_o, held == CAP);
    chk(valid_o == (cq.size() > 0), "R2 valid_o", valid_o, cq.size() > 0);
    if (cq.size() > 0) chk(data_o == cq[0], "R6 data_o", data_o, cq[0]);
    chk(fill_lvl_o == quant(cq.size()), "R9 fill_lvl_o", fill_lvl_o, quant(cq.size()));
    chk(free_lvl_o == quant(CAP - held), "R10 free_lvl_o", free_lvl_o, quant(CAP - held));
  endtask

  // drive at negedge, model the edge, compare at the following negedge
  task automatic cycle(input bit p, input logic [7:0] d, input bit c,
                       input bit r, input bit g);
    bit acc = p && (cq.size() + pq.size() < CAP);
    put_i = p; data_i = d; commit_i = c; rollback_i = r; got_i = g;
    if (g && cq.size() > 0) void'(cq.pop_front());
    if (acc) pq.push_back(d);
    if (c) begin
      foreach (pq[i]) cq.push_back(pq[i]);
      pq.delete();
    end
    if (r) pq.delete();
    @(negedge clk);
    put_i = 0; commit_i = 0; rollback_i = 0; got_i = 0;
    compare();
  endtask

  initial begin
    #(50000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(valid_o == 0, "R8 valid_o", valid_o, 0);
    chk(full_o == 0, "R8 full_o", full_o, 0);
    chk(fill_lvl_o == 0, "R8 fill_lvl_o", fill_lvl_o, 0);
    chk(free_lvl_o == 3, "R8 free_lvl_o", free_lvl_o, 3);

    // R7 got on empty queue changes nothing
    cycle(0, 0, 0, 0, 1);
    cycle(1, 8'hA5, 1, 0, 0);
    chk(data_o == 8'hA5, "R7 head after empty got", data_o, 8'hA5);
    cycle(0, 0, 0, 0, 1);

    // R1/R3 fill with tentative words: full while not valid, extra put ignored
    for (int i = 0; i < CAP; i++) cycle(1, 8'(i + 16), 0, 0, 0);
    chk(full_o == 1 && valid_o == 0, "R3 full without valid", {full_o, valid_o}, 2);
    cycle(1, 8'hEE, 0, 0, 0);
    cycle(0, 0, 1, 0, 0);
    // R11 drain in order, extra put must not appear
    for (int i = 0; i < CAP; i++) begin
      chk(data_o == 8'(i + 16), "R11 order", data_o, i + 16);
      cycle(0, 0, 0, 0, 1);
    end
    chk(valid_o == 0, "R3 ignored put absent", valid_o, 0);

    // R5 rollback drops earlier and same-cycle puts, frees space
    cycle(1, 8'h01, 0, 0, 0);
    cycle(1, 8'h02, 0, 0, 0);
    cycle(1, 8'h03, 0, 1, 0);
    chk(valid_o == 0 && free_lvl_o == 3, "R5 rollback", {valid_o, free_lvl_o}, 3);
    // R4 commit includes same-cycle put
    cycle(1, 8'h44, 0, 0, 0);
    cycle(1, 8'h55, 1, 0, 0);
    chk(valid_o == 1 && data_o == 8'h44, "R4 commit head", data_o, 8'h44);
    cycle(0, 0, 0, 0, 1);
    chk(data_o == 8'h55, "R4 same-cycle put committed", data_o, 8'h55);
    cycle(0, 0, 0, 0, 1);

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 19);
      bit c = (sel == 0) || (sel == 1) || (sel == 2);
      bit r = (sel == 3);
      cycle(($urandom_range(0, 2) != 0), 8'($urandom), c, r,
            ($urandom_range(0, 2) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule